// File: doc/BRIEF.md
# Edge-Selectable Multi-Pin Wake and Interrupt Unit

This block watches an eight-bit input port and turns chosen pin transitions into a wake request for the power-mode controller. A detected transition ends the HALT or IDLE state. The same detected transitions can also serve as up to eight external interrupt sources while the device is running. For each pin, software picks the active edge and decides whether that pin may wake the device. Every detected edge is recorded in a sticky pending bit. The wake output is raised while any pin has both its pending bit and its enable bit set. The interrupt output is that same condition, further qualified by one global interrupt enable.

The pins are brought into the clock domain by a synchronizer chain of configurable depth. A per-pin edge detector follows the chain. Software reaches the block through a plain register port: a write strobe with an address and data, and a read address with combinational read data. There is no data stream and no handshake, so there is no back-pressure: a write takes effect on the clock edge that samples the strobe. The wake and interrupt outputs are plain levels. To change the edge select of a pin safely, software first disables the pin, then changes the select, then clears the pin's pending bit, and only then enables the pin again.

Top module: `pin_wake_unit`

## Requirements
- R1: After reset, the enable, edge-select, pending and control registers all read 0, and `wake_o` and `irq_o` are low.
- R2: When a pin's edge-select bit is 0, a rising transition on that pin sets its pending bit. Pins change between clock edges. The bit reads 1 after the third rising clock edge that follows the pin change.
- R3: When a pin's edge-select bit is 1, a falling transition on that pin sets its pending bit, with the same latency as R2.
- R4: A transition in the direction not selected for a pin leaves that pin's pending bit at 0.
- R5: Pending bits latch detected edges whatever the state of the enable bits. A pending bit stays set until software clears it.
- R6: `wake_o` is high exactly when some bit is set in both the pending register and the enable register.
- R7: `irq_o` equals `wake_o` when bit 0 of the control register (the global interrupt enable) is 1, and is low otherwise.
- R8: Writing to the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. If an edge is detected on the same clock edge as a clear of that bit, the bit stays set.
- R9: The register addresses are: 0 for enable, 1 for edge select, 2 for pending (write 1 to clear), and 3 for control, where bit 0 is the global interrupt enable and the upper bits read 0. `reg_rdata` follows `reg_raddr` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 8 | Monitored port pins, asynchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | 8 | Read data for reg_raddr, combinational |
| wake_o | output | 1 | Wake request to the power-mode controller |
| irq_o | output | 1 | External interrupt request |

## Verification
A pin change made between clock edges passes through two synchronizer flops. The edge detector then compares against the stored previous level, and the result is registered into the pending bit. As a result, the pending bit, `wake_o` and `irq_o` all reflect the change only after the third rising clock edge. A register write is visible after the single edge that samples it. The bench drives every input on the falling clock edge. It waits exactly three falling edges after a pin change, and one falling edge after a write, before it samples the outputs. The set-versus-clear collision case places the clear write on the same edge that registers the edge event.

// File: rtl/pin_wake_pkg.sv
package pin_wake_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_ENABLE = 2'd0,
    REG_EDGE   = 2'd1,
    REG_PEND   = 2'd2,
    REG_CTRL   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_edge_detect.sv
module pin_edge_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] fall_sel_i,
  output logic [WIDTH-1:0] event_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic rise, fall;
    assign rise = ~prev_q[b] &  level_i[b];
    assign fall =  prev_q[b] & ~level_i[b];
    assign event_o[b] = fall_sel_i[b] ? fall : rise;
  end
endmodule

// File: rtl/pin_wake_regs.sv
module pin_wake_regs
  import pin_wake_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [REG_AW-1:0] waddr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [REG_AW-1:0] raddr_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  event_i,
  output logic [WIDTH-1:0]  enable_o,
  output logic [WIDTH-1:0]  fall_sel_o,
  output logic [WIDTH-1:0]  pend_o,
  output logic              gie_o
);
  logic [WIDTH-1:0] enable_q, sel_q, pend_q;
  logic             gie_q;
  logic [WIDTH-1:0] clr_mask;

  assign clr_mask = (we_i && waddr_i == REG_PEND) ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      sel_q    <= '0;
      gie_q    <= 1'b0;
    end else if (we_i) begin
      case (waddr_i)
        REG_ENABLE: enable_q <= wdata_i;
        REG_EDGE:   sel_q    <= wdata_i;
        REG_CTRL:   gie_q    <= wdata_i[0];
        default:    ;
      endcase
    end
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | event_i;
  end

  always_comb begin
    case (raddr_i)
      REG_ENABLE: rdata_o = enable_q;
      REG_EDGE:   rdata_o = sel_q;
      REG_PEND:   rdata_o = pend_q;
      default:    rdata_o = {{(WIDTH-1){1'b0}}, gie_q};
    endcase
  end

  assign enable_o   = enable_q;
  assign fall_sel_o = sel_q;
  assign pend_o     = pend_q;
  assign gie_o      = gie_q;
endmodule

// File: rtl/pin_wake_unit.sv
module pin_wake_unit
  import pin_wake_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  pins_i,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [WIDTH-1:0]  reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [WIDTH-1:0]  reg_rdata,
  output logic              wake_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] level_w, event_w, enable_w, fall_sel_w, pend_w;
  logic             gie_w;

  pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(pins_i), .sync_o(level_w)
  );

  pin_edge_detect #(.WIDTH(WIDTH)) edge_i (
    .clk(clk), .rst_n(rst_n), .level_i(level_w),
    .fall_sel_i(fall_sel_w), .event_o(event_w)
  );

  pin_wake_regs #(.WIDTH(WIDTH)) regs_i (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .waddr_i(reg_waddr),
    .wdata_i(reg_wdata), .raddr_i(reg_raddr), .rdata_o(reg_rdata),
    .event_i(event_w), .enable_o(enable_w), .fall_sel_o(fall_sel_w),
    .pend_o(pend_w), .gie_o(gie_w)
  );

  assign wake_o = |(pend_w & enable_w);
  assign irq_o  = wake_o & gie_w;
endmodule

// File: rtl/pin_wake_chk.sv
module pin_wake_chk
  import pin_wake_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_waddr,
  input logic [WIDTH-1:0]  reg_wdata,
  input logic [WIDTH-1:0]  evt,
  input logic [WIDTH-1:0]  pend,
  input logic              wake_o,
  input logic              irq_o
);
  logic pend_wr;
  assign pend_wr = reg_we && (reg_waddr == REG_PEND);

  // R1: pending register empty on leaving reset
  assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pend == '0 && !wake_o));

  // R2 / R3: a detected edge is recorded on the next clock
  assert_event_sets_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt) & ~pend) == '0));

  // R5: pending bits only drop through a clear write
  assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr |=> (($past(pend) & ~pend) == '0));

  // R7: interrupt never raised without wake
  assert_irq_needs_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> wake_o);

  // R8: written ones clear bits with no simultaneous event
  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> ((pend & $past(reg_wdata) & ~$past(evt)) == '0));
endmodule

bind pin_wake_unit pin_wake_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
  .reg_wdata(reg_wdata), .evt(event_w), .pend(pend_w),
  .wake_o(wake_o), .irq_o(irq_o)
);

// File: tb/pin_wake_unit_tb.sv
module pin_wake_unit_tb_top;
  localparam int W = 8;
  localparam logic [1:0] A_EN = 2'd0, A_EDGE = 2'd1, A_PEND = 2'd2, A_CTRL = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] pins = '0;
  logic reg_we = 1'b0;
  logic [1:0] reg_waddr = '0, reg_raddr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic wake_o, irq_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_wake_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
    .reg_rdata(reg_rdata), .wake_o(wake_o), .irq_o(irq_o)
  );

  function automatic logic [W-1:0] exp_edges(logic [W-1:0] was, logic [W-1:0] now,
                                             logic [W-1:0] fall);
    return (~fall & ~was & now) | (fall & was & ~now);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] d);
    reg_raddr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_pins(logic [W-1:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 and R9: reset values at every address
    rd(A_EN, d);   check("R1 enable reset", d, 0);
    rd(A_EDGE, d); check("R1 edge reset", d, 0);
    rd(A_PEND, d); check("R1 pending reset", d, 0);
    rd(A_CTRL, d); check("R1 ctrl reset", d, 0);
    check("R1 wake reset", wake_o, 0);
    check("R1 irq reset", irq_o, 0);

    // R9: read-back, control upper bits read 0
    wr(A_EN, 8'hA5);   rd(A_EN, d);   check("R9 enable readback", d, 8'hA5);
    wr(A_EDGE, 8'h3C); rd(A_EDGE, d); check("R9 edge readback", d, 8'h3C);
    wr(A_CTRL, 8'hFF); rd(A_CTRL, d); check("R9 ctrl readback", d, 8'h01);

    // R5: edge on disabled pin latches, wake stays low
    wr(A_EN, 8'h00); wr(A_EDGE, 8'h00); wr(A_CTRL, 8'h01);
    set_pins(8'h01);
    rd(A_PEND, d); check("R5 pend latched while disabled", d, 8'h01);
    check("R5 no wake while disabled", wake_o, 0);
    wr(A_EN, 8'h01);
    check("R6 wake after enable", wake_o, 1);
    check("R7 irq with gie", irq_o, 1);
    wr(A_CTRL, 8'h00);
    check("R7 irq masked by gie", irq_o, 0);
    check("R6 wake unaffected by gie", wake_o, 1);

    // R8: zero bits leave pending unchanged, one bits clear
    wr(A_PEND, 8'hFE); rd(A_PEND, d); check("R8 zero write keeps bit", d, 8'h01);
    wr(A_PEND, 8'h01); rd(A_PEND, d); check("R8 one write clears bit", d, 8'h00);
    check("R6 wake low after clear", wake_o, 0);

    // R4: falling edge with rising select is ignored
    set_pins(8'h00);
    rd(A_PEND, d); check("R4 opposite edge ignored", d, 8'h00);

    // R3: falling edge with falling select
    wr(A_EDGE, 8'h02); set_pins(8'h02); rd(A_PEND, d);
    check("R4 rising ignored on falling pin", d, 8'h00);
    set_pins(8'h00); rd(A_PEND, d); check("R3 falling edge sets bit", d, 8'h02);
    wr(A_PEND, 8'hFF); wr(A_EDGE, 8'h00);

    // R8: set wins over a same-cycle clear
    @(negedge clk); pins = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_we = 1'b1; reg_waddr = A_PEND; reg_wdata = 8'h01;
    @(negedge clk); reg_we = 1'b0;
    rd(A_PEND, d); check("R8 set beats clear", d, 8'h01);
    wr(A_PEND, 8'h01); rd(A_PEND, d); check("R8 cleared afterwards", d, 8'h00);

    // R2 latency: not yet set after two edges, set after three
    @(negedge clk); pins = 8'h81;
    @(negedge clk); @(negedge clk);
    rd(A_PEND, d); check("R2 not early", d, 8'h00);
    @(negedge clk);
    rd(A_PEND, d); check("R2 rising edge sets bit", d, 8'h80);

    // random patterns: R2 R3 R4 R6 R7
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] en, sel, nv, exp_p;
      logic g;
      en = W'($urandom); sel = W'($urandom); g = 1'($urandom); nv = W'($urandom);
      wr(A_EN, en); wr(A_EDGE, sel); wr(A_CTRL, {7'd0, g}); wr(A_PEND, 8'hFF);
      exp_p = exp_edges(pins, nv, sel);
      set_pins(nv);
      rd(A_PEND, d); check("R2/R3 random pending", d, exp_p);
      check("R6 random wake", wake_o, |(exp_p & en));
      check("R7 random irq", irq_o, g & |(exp_p & en));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule